// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block decides whether a branch instruction is taken and supplies its destination. It takes the 8-bit operation code, the value of the register named as the first operand, three stored comparison flags (less, equal, greater) and the already-resolved second operand. Branches use the second operand as the destination address without any memory fetch.

There are thirteen branch codes in the range 0x20 to 0x2C. One jumps unconditionally. Six look at the sign and zero state of the register. The other six look only at the comparison flags and ignore the register. For every other code the block reports the code as invalid and does not take the branch.

The verdict can leave the block combinationally, or from an output register one cycle later. A parameter chooses between the two. The program counter update, subroutine linkage and stack work belong to the surrounding core.

Top module: `cond_branch_eval`

## Requirements
- R1: Code 0x20 is always taken, whatever the register value and the flags hold.
- R2: Taking the register as signed two's complement, code 0x21 is taken when it is negative (top bit 1), 0x22 when it is zero, and 0x23 when it is positive (top bit 0 and nonzero). Zero is neither positive nor negative.
- R3: Codes 0x24, 0x25 and 0x26 are taken exactly when 0x21, 0x22 and 0x23 respectively would not be.
- R4: Codes 0x27, 0x28 and 0x29 are taken when the less, equal and greater flag respectively is 1.
- R5: Codes 0x2A, 0x2B and 0x2C are taken exactly when 0x27, 0x28 and 0x29 would not be, so with all three flags at 0 (no comparison since reset) each of them is taken.
- R6: The flag-testing codes give the same verdict for every register value, and the register-testing codes give the same verdict for every flag combination.
- R7: For every code from 0x20 to 0x2C the target output equals the second operand, taken or not. For any other code the target is 0.
- R8: Any code below 0x20 or above 0x2C drives invalid to 1 and taken to 0. Codes 0x20 to 0x2C drive invalid to 0.
- R9: With OUT_REG = 0 the outputs follow the inputs in the same cycle. With OUT_REG = 1 they show the verdict for the inputs present at the previous rising clock edge, and while reset is low they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_code | input | 8 | Operation code of the instruction |
| rj_val | input | DATA_W | Value of the first-operand register |
| flag_less | input | 1 | Stored comparison result: less |
| flag_equal | input | 1 | Stored comparison result: equal |
| flag_greater | input | 1 | Stored comparison result: greater |
| operand | input | ADDR_W | Resolved second operand (destination address) |
| br_taken | output | 1 | Branch is taken |
| br_target | output | ADDR_W | Destination address |
| br_invalid | output | 1 | Code is not a branch |

## Verification
The bench builds two copies with DATA_W = 8 and ADDR_W = 16. One copy has OUT_REG = 0 and the other has OUT_REG = 1, and both get the same stimulus. The narrow register lets every one of the 256 register values meet every branch code under all eight flag combinations. This covers the sign boundaries 0x7F, 0x80 and 0x00, and shows directly that each class ignores the input it should not use. Every non-branch code is also applied. The registered copy is checked one edge later and during reset.

// File: rtl/cbe_pkg.sv
package cbe_pkg;

   localparam logic [7:0] OPC_FIRST = 8'h20;
   localparam logic [7:0] OPC_LAST  = 8'h2C;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'd0,
      CLS_ALWAYS = 2'd1,
      CLS_REG    = 2'd2,
      CLS_FLAG   = 2'd3
   } br_class_e;

   // sel: 0 = negative / less, 1 = zero / equal, 2 = positive / greater
   typedef struct packed {
      br_class_e  cls;
      logic [1:0] sel;
      logic       inv;
   } br_ctl_t;

endpackage

// File: rtl/cbe_decode.sv
module cbe_decode
   import cbe_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] op_code,
   output br_ctl_t    ctl
);

   always_comb begin
      ctl = '{cls: CLS_NONE, sel: 2'd0, inv: 1'b0};
      case (op_code)
         8'h20: ctl = '{cls: CLS_ALWAYS, sel: 2'd0, inv: 1'b0};
         8'h21: ctl = '{cls: CLS_REG,    sel: 2'd0, inv: 1'b0};
         8'h22: ctl = '{cls: CLS_REG,    sel: 2'd1, inv: 1'b0};
         8'h23: ctl = '{cls: CLS_REG,    sel: 2'd2, inv: 1'b0};
         8'h24: ctl = '{cls: CLS_REG,    sel: 2'd0, inv: 1'b1};
         8'h25: ctl = '{cls: CLS_REG,    sel: 2'd1, inv: 1'b1};
         8'h26: ctl = '{cls: CLS_REG,    sel: 2'd2, inv: 1'b1};
         8'h27: ctl = '{cls: CLS_FLAG,   sel: 2'd0, inv: 1'b0};
         8'h28: ctl = '{cls: CLS_FLAG,   sel: 2'd1, inv: 1'b0};
         8'h29: ctl = '{cls: CLS_FLAG,   sel: 2'd2, inv: 1'b0};
         8'h2A: ctl = '{cls: CLS_FLAG,   sel: 2'd0, inv: 1'b1};
         8'h2B: ctl = '{cls: CLS_FLAG,   sel: 2'd1, inv: 1'b1};
         8'h2C: ctl = '{cls: CLS_FLAG,   sel: 2'd2, inv: 1'b1};
         default: ;
      endcase
   end

   assert_range_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_code < OPC_FIRST) || (op_code > OPC_LAST)) |-> (ctl.cls == CLS_NONE));

   assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.cls != CLS_NONE) |-> (ctl.sel != 2'd3));

endmodule

// File: rtl/cbe_sign_zero.sv
module cbe_sign_zero #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rj_val,
   output logic              is_neg,
   output logic              is_zero,
   output logic              is_pos
);

   localparam int SIGN_BIT = DATA_W - 1;

   always_comb begin
      is_neg  = rj_val[SIGN_BIT];
      is_zero = (rj_val == '0);
      is_pos  = !rj_val[SIGN_BIT] && (rj_val != '0);
   end

   assert_one_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({is_neg, is_zero, is_pos}) == 1);

endmodule

// File: rtl/cbe_cond_mux.sv
module cbe_cond_mux
   import cbe_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  br_ctl_t ctl,
   input  logic    is_neg,
   input  logic    is_zero,
   input  logic    is_pos,
   input  logic    flag_less,
   input  logic    flag_equal,
   input  logic    flag_greater,
   output logic    taken
);

   logic [2:0] reg_vec;
   logic [2:0] flag_vec;
   logic       reg_hit;
   logic       flag_hit;

   always_comb begin
      reg_vec  = {is_pos, is_zero, is_neg};
      flag_vec = {flag_greater, flag_equal, flag_less};
      reg_hit  = (ctl.sel == 2'd3) ? 1'b0 : reg_vec[ctl.sel];
      flag_hit = (ctl.sel == 2'd3) ? 1'b0 : flag_vec[ctl.sel];
      unique case (ctl.cls)
         CLS_ALWAYS: taken = 1'b1;
         CLS_REG:    taken = reg_hit ^ ctl.inv;
         CLS_FLAG:   taken = flag_hit ^ ctl.inv;
         default:    taken = 1'b0;
      endcase
   end

   assert_none_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.cls == CLS_NONE) |-> !taken);

   assert_always_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.cls == CLS_ALWAYS) |-> taken);

   assert_no_flags_negated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl.cls == CLS_FLAG) && ctl.inv && !flag_less && !flag_equal && !flag_greater) |-> taken);

endmodule

// File: rtl/cond_branch_eval.sv
module cond_branch_eval
   import cbe_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 16,
   parameter int OUT_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        op_code,
   input  logic [DATA_W-1:0] rj_val,
   input  logic              flag_less,
   input  logic              flag_equal,
   input  logic              flag_greater,
   input  logic [ADDR_W-1:0] operand,
   output logic              br_taken,
   output logic [ADDR_W-1:0] br_target,
   output logic              br_invalid
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("cond_branch_eval: DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("cond_branch_eval: ADDR_W must be at least 1");
      end
      if ((OUT_REG != 0) && (OUT_REG != 1)) begin : g_bad_out_reg
         $error("cond_branch_eval: OUT_REG must be 0 or 1");
      end
   endgenerate

   br_ctl_t           ctl;
   logic              is_neg;
   logic              is_zero;
   logic              is_pos;
   logic              taken_d;
   logic              invalid_d;
   logic [ADDR_W-1:0] target_d;

   cbe_decode u_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_code (op_code),
      .ctl     (ctl)
   );

   cbe_sign_zero #(.DATA_W(DATA_W)) u_sign_zero (
      .clk     (clk),
      .rst_n   (rst_n),
      .rj_val  (rj_val),
      .is_neg  (is_neg),
      .is_zero (is_zero),
      .is_pos  (is_pos)
   );

   cbe_cond_mux u_cond_mux (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl          (ctl),
      .is_neg       (is_neg),
      .is_zero      (is_zero),
      .is_pos       (is_pos),
      .flag_less    (flag_less),
      .flag_equal   (flag_equal),
      .flag_greater (flag_greater),
      .taken        (taken_d)
   );

   always_comb begin
      invalid_d = (ctl.cls == CLS_NONE);
      target_d  = invalid_d ? '0 : operand;
   end

   generate
      if (OUT_REG == 1) begin : g_registered
         logic              taken_q;
         logic              invalid_q;
         logic [ADDR_W-1:0] target_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               taken_q   <= 1'b0;
               invalid_q <= 1'b0;
               target_q  <= '0;
            end else begin
               taken_q   <= taken_d;
               invalid_q <= invalid_d;
               target_q  <= target_d;
            end
         end

         assign br_taken   = taken_q;
         assign br_invalid = invalid_q;
         assign br_target  = target_q;

         assert_reg_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((br_taken == $past(taken_d)) && (br_target == $past(target_d))));
      end else begin : g_direct
         assign br_taken   = taken_d;
         assign br_invalid = invalid_d;
         assign br_target  = target_d;
      end
   endgenerate

   assert_invalid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      br_invalid |-> (!br_taken && (br_target == '0)));

   assert_target_operand_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_code >= OPC_FIRST) && (op_code <= OPC_LAST)) |-> (target_d == operand));

endmodule

// File: tb/test_cond_branch_eval.sv
`timescale 1ns/1ps
module test_cond_branch_eval;

   localparam int DW = 8;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    op = 8'h20;
   logic [DW-1:0] rj = '0;
   logic          fl = 1'b0;
   logic          fe = 1'b0;
   logic          fg = 1'b0;
   logic [AW-1:0] opnd = 16'h1234;

   logic          c_taken, c_inv, q_taken, q_inv;
   logic [AW-1:0] c_tgt, q_tgt;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cond_branch_eval #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(0)) i_cond_branch_eval (
      .clk(clk), .rst_n(rst_n), .op_code(op), .rj_val(rj),
      .flag_less(fl), .flag_equal(fe), .flag_greater(fg), .operand(opnd),
      .br_taken(c_taken), .br_target(c_tgt), .br_invalid(c_inv)
   );

   cond_branch_eval #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1)) i_cond_branch_eval_q (
      .clk(clk), .rst_n(rst_n), .op_code(op), .rj_val(rj),
      .flag_less(fl), .flag_equal(fe), .flag_greater(fg), .operand(opnd),
      .br_taken(q_taken), .br_target(q_tgt), .br_invalid(q_inv)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s op=%02h rj=%02h flags=%0d%0d%0d actual=%0h expected=%0h",
                  req, what, op, rj, fl, fe, fg, got, exp);
      end
   endtask

   function automatic string req_of(input logic [7:0] o);
      if (o == 8'h20) return "R1";
      if (o >= 8'h21 && o <= 8'h23) return "R2";
      if (o >= 8'h24 && o <= 8'h26) return "R3";
      if (o >= 8'h27 && o <= 8'h29) return "R4";
      if (o >= 8'h2A && o <= 8'h2C) return "R5";
      return "R8";
   endfunction

   function automatic bit exp_taken(input logic [7:0] o, input logic [DW-1:0] v,
                                    input logic l, input logic e, input logic g);
      int s;
      s = $signed(v);
      case (o)
         8'h20: return 1'b1;
         8'h21: return s < 0;
         8'h22: return s == 0;
         8'h23: return s > 0;
         8'h24: return !(s < 0);
         8'h25: return !(s == 0);
         8'h26: return !(s > 0);
         8'h27: return l;
         8'h28: return e;
         8'h29: return g;
         8'h2A: return !l;
         8'h2B: return !e;
         8'h2C: return !g;
         default: return 1'b0;
      endcase
   endfunction

   task automatic apply(input logic [7:0] o, input logic [DW-1:0] v, input logic [2:0] f,
                        input logic [AW-1:0] a);
      bit valid;
      bit et;
      string r;
      @(negedge clk);
      op = o; rj = v; fl = f[2]; fe = f[1]; fg = f[0]; opnd = a;
      valid = (o >= 8'h20) && (o <= 8'h2C);
      et = exp_taken(o, v, f[2], f[1], f[0]);
      r = req_of(o);
      #1;
      chk(r, "taken", c_taken, et);
      chk(valid ? "R7" : "R8", "target", c_tgt, valid ? a : 0);
      chk("R8", "invalid", c_inv, !valid);
      @(posedge clk);
      #1;
      chk("R9", "reg taken", q_taken, et);
      chk("R9", "reg target", q_tgt, valid ? a : 0);
      chk("R9", "reg invalid", q_inv, !valid);
   endtask

   initial begin : watchdog
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      // reset state: registered copy quiet, direct copy already evaluating
      repeat (3) @(posedge clk);
      #1;
      chk("R9", "reset taken", q_taken, 0);
      chk("R9", "reset target", q_tgt, 0);
      chk("R9", "reset invalid", q_inv, 0);
      chk("R1", "direct in reset", c_taken, 1);
      @(negedge clk);
      rst_n = 1'b1;

      // all branch codes x all register values x all flag combinations (R6 sweep)
      for (int o = 8'h20; o <= 8'h2C; o++) begin
         for (int v = 0; v < 256; v++) begin
            for (int f = 0; f < 8; f++) begin
               apply(8'(o), DW'(v), 3'(f), 16'((o << 8) ^ (v * 37) ^ f));
            end
         end
      end

      // every non-branch code with a few register/flag patterns
      for (int o = 0; o < 256; o++) begin
         if (o < 8'h20 || o > 8'h2C) begin
            for (int p = 0; p < 4; p++) begin
               apply(8'(o), DW'(p * 67), 3'(p * 3), 16'(16'hBEEF ^ o ^ p));
            end
         end
      end

      // reset reasserted: registered copy returns to zero
      @(negedge clk);
      op = 8'h20;
      rst_n = 1'b0;
      #1;
      chk("R9", "re-reset taken", q_taken, 0);
      chk("R9", "re-reset target", q_tgt, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule